// File: doc/BRIEF.md
# Write-Window Dirty Block Tracker

This block records which blocks of an open write window have been modified and still have to be written back to storage. It keeps one dirty bit for each block of the window. Two kinds of request set those bits. A mark request gives a starting block index and a length in bytes. An erase request gives a starting block index and a length in blocks. A mark only ever covers whole blocks. Its byte length is rounded up to a block count using a block size that is a power of two, supplied as an exponent.

When a flush is requested, the tracker repeatedly picks the lowest-numbered dirty block. It presents that block index on a ready/valid write-back port and clears the bit once the consumer accepts it. When no dirty bits remain, it reports completion with a one-cycle pulse. Closing the write window is handled by issuing the same flush. A wipe input throws away all dirty state at once, for example when the management side restarts, and it aborts any flush in progress.

Top module: `dirty_tracker`

## Requirements
- R1: After synchronous reset, no block is dirty and `wb_valid`, `flush_busy`, `flush_done` and `req_err` are all low.
- R2: A mark request (`req_kind`=0) with byte length L and exponent E sets blocks `req_start` up to `req_start`+ceil(L/2^E)-1, so a partly written block is marked whole.
- R3: A mark request with a byte length of zero sets no bit and raises no error, provided its start lies within the window.
- R4: An erase request (`req_kind`=1) with block count C sets blocks `req_start` up to `req_start`+C-1.
- R5: A request whose end (start plus block count) exceeds `win_blocks` (clamped to NUM_BLOCKS) changes no bit. It raises `req_err` for exactly the cycle after it is sampled. A request that ends exactly at the window limit is accepted.
- R6: During a flush, `wb_valid` presents one dirty block index at a time, always the lowest one still dirty. While `wb_ready` is low, `wb_valid` and `wb_index` hold steady.
- R7: A block's dirty bit is cleared when its write-back is accepted (`wb_valid` and `wb_ready` both high at a clock edge). A block that is marked repeatedly is therefore emitted only once per flush.
- R8: A flush that finds no dirty bit left ends with `flush_done` high for one cycle, with `flush_busy` and `wb_valid` low at the same time. `flush_start` is ignored while a flush is busy.
- R9: `wipe` clears every dirty bit and aborts any flush: `wb_valid` and `flush_busy` are low after that edge, and a request in the same cycle sets nothing.
- R10: A flush started with nothing dirty raises `flush_done` two edges after `flush_start` is sampled and emits no index.
- R11: A block marked while a flush is running is written back by that same flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_exp | input | 5 | Block size as a power-of-two exponent, in bytes |
| win_blocks | input | 16 | Size of the open window in blocks |
| req_valid | input | 1 | A mark or erase request is present this cycle |
| req_kind | input | 1 | 0 = mark (length in bytes), 1 = erase (length in blocks) |
| req_start | input | 16 | First block of the request, relative to the window |
| req_len | input | 32 | Byte count (mark) or block count (erase) |
| req_err | output | 1 | Request rejected for exceeding the window (registered pulse) |
| wipe | input | 1 | Discard all dirty state and abort a flush |
| flush_start | input | 1 | Begin writing back dirty blocks |
| flush_busy | output | 1 | A flush is in progress |
| flush_done | output | 1 | One-cycle pulse when a flush completes |
| wb_valid | output | 1 | A block index is offered for write-back |
| wb_index | output | 16 | Block index being offered |
| wb_ready | input | 1 | Consumer accepts the offered block |

## Verification
The bench drives mark lengths that fall exactly on a block boundary, lengths one byte past a boundary, and zero lengths, under two block exponents. These show whether rounding up and the zero-length case behave differently from a plain shift. Erase requests that end exactly at the window limit, and ones that end one block past it, separate the accepted boundary from the rejected one. Flushes run with both an always-ready consumer and a stalling consumer, with marks that land mid-flush, and with wipes that land mid-flush. A random phase compares every cycle against a behavioural bitmap model.

// File: rtl/dtrk_pkg.sv
package dtrk_pkg;
  typedef enum logic { KIND_MARK = 1'b0, KIND_ERASE = 1'b1 } req_kind_e;
endpackage

// File: rtl/dtrk_span.sv
// Converts a request into a block range, checks it against the window
// and produces the set mask for the bitmap.
module dtrk_span #(
  parameter int NUM_BLOCKS = 64
) (
  input  logic                  req_valid,
  input  logic                  req_kind,
  input  logic [15:0]           req_start,
  input  logic [31:0]           req_len,
  input  logic [4:0]            blk_exp,
  input  logic [15:0]           win_blocks,
  output logic                  range_ok,
  output logic                  range_err,
  output logic [NUM_BLOCKS-1:0] set_mask
);
  import dtrk_pkg::*;

  localparam logic [16:0] NB17 = 17'(NUM_BLOCKS);

  logic [32:0] round_add;
  logic [32:0] blk_cnt;
  logic [33:0] end_blk;
  logic [16:0] limit;

  always_comb begin
    round_add = (33'd1 << blk_exp) - 33'd1;
    if (req_kind == KIND_ERASE)
      blk_cnt = {1'b0, req_len};
    else
      blk_cnt = ({1'b0, req_len} + round_add) >> blk_exp;
    end_blk   = {18'd0, req_start} + {1'b0, blk_cnt};
    limit     = ({1'b0, win_blocks} > NB17) ? NB17 : {1'b0, win_blocks};
    range_ok  = req_valid && (end_blk <= {17'd0, limit});
    range_err = req_valid && !(end_blk <= {17'd0, limit});
  end

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_mask
    localparam logic [33:0] IDX = 34'(i);
    assign set_mask[i] = range_ok && (IDX >= {18'd0, req_start}) && (IDX < end_blk);
  end
endmodule

// File: rtl/dtrk_bitmap.sv
// One dirty flag per block; set mask ORed in after the single clear.
module dtrk_bitmap #(
  parameter int NUM_BLOCKS = 64,
  localparam int IW = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wipe,
  input  logic [NUM_BLOCKS-1:0] set_mask,
  input  logic                  clr_en,
  input  logic [IW-1:0]         clr_idx,
  output logic [NUM_BLOCKS-1:0] bits
);
  logic [NUM_BLOCKS-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) bits <= '0;
    else             bits <= (bits & ~clr_mask) | set_mask;
  end

  a_r9_wipe_empties: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (bits == '0));
endmodule

// File: rtl/dtrk_scan.sv
// Flush sequencer: lowest-set-bit search and ready/valid write-back.
module dtrk_scan #(
  parameter int NUM_BLOCKS = 64,
  localparam int IW = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wipe,
  input  logic                  flush_start,
  input  logic [NUM_BLOCKS-1:0] bits,
  input  logic                  wb_ready,
  output logic                  wb_valid,
  output logic [IW-1:0]         wb_idx,
  output logic                  busy,
  output logic                  done,
  output logic                  clr_en,
  output logic [IW-1:0]         clr_idx
);
  logic          any_dirty;
  logic [IW-1:0] lowest;

  always_comb begin
    any_dirty = |bits;
    lowest    = '0;
    for (int i = NUM_BLOCKS - 1; i >= 0; i--)
      if (bits[i]) lowest = IW'(i);
  end

  assign clr_en  = wb_valid && wb_ready && !wipe;
  assign clr_idx = wb_idx;

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (wb_valid) begin
          if (wb_ready) wb_valid <= 1'b0;
        end else if (any_dirty) begin
          wb_valid <= 1'b1;
          wb_idx   <= lowest;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (flush_start) begin
        busy <= 1'b1;
      end
    end
  end

  a_r6_hold_offer: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready && !wipe) |=> (wb_valid && $stable(wb_idx)));
  a_r7_offer_is_dirty: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> bits[wb_idx]);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !wb_valid));
  a_r9_wipe_aborts: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (!busy && !wb_valid));
endmodule

// File: rtl/dirty_tracker.sv
module dirty_tracker #(
  parameter int NUM_BLOCKS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  blk_exp,
  input  logic [15:0] win_blocks,
  input  logic        req_valid,
  input  logic        req_kind,
  input  logic [15:0] req_start,
  input  logic [31:0] req_len,
  output logic        req_err,
  input  logic        wipe,
  input  logic        flush_start,
  output logic        flush_busy,
  output logic        flush_done,
  output logic        wb_valid,
  output logic [15:0] wb_index,
  input  logic        wb_ready
);
  localparam int IW = $clog2(NUM_BLOCKS);

  logic                  range_ok, range_err;
  logic [NUM_BLOCKS-1:0] span_mask, set_mask, bits;
  logic                  clr_en;
  logic [IW-1:0]         clr_idx, wb_idx;

  dtrk_span #(.NUM_BLOCKS(NUM_BLOCKS)) u_span (
    .req_valid(req_valid), .req_kind(req_kind), .req_start(req_start),
    .req_len(req_len), .blk_exp(blk_exp), .win_blocks(win_blocks),
    .range_ok(range_ok), .range_err(range_err), .set_mask(span_mask)
  );

  assign set_mask = wipe ? '0 : span_mask;

  dtrk_bitmap #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
    .clk(clk), .rst(rst), .wipe(wipe), .set_mask(set_mask),
    .clr_en(clr_en), .clr_idx(clr_idx), .bits(bits)
  );

  dtrk_scan #(.NUM_BLOCKS(NUM_BLOCKS)) u_scan (
    .clk(clk), .rst(rst), .wipe(wipe), .flush_start(flush_start),
    .bits(bits), .wb_ready(wb_ready), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .busy(flush_busy), .done(flush_done), .clr_en(clr_en), .clr_idx(clr_idx)
  );

  assign wb_index = 16'(wb_idx);

  always_ff @(posedge clk) begin
    if (rst) req_err <= 1'b0;
    else     req_err <= range_err;
  end

  a_r5_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (req_err && !$past(range_err)) |-> 1'b0);
  a_r1_ok_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(range_ok && req_err && !$past(req_valid)));
endmodule

// File: tb/dirty_tracker_test.sv
module dirty_tracker_test;
  localparam int NB = 64;

  logic        clk = 0, rst = 1;
  logic [4:0]  blk_exp = 5'd4;
  logic [15:0] win_blocks = 16'd40;
  logic        req_valid = 0, req_kind = 0;
  logic [15:0] req_start = 0;
  logic [31:0] req_len = 0;
  logic        req_err, wipe = 0, flush_start = 0;
  logic        flush_busy, flush_done, wb_valid, wb_ready = 1;
  logic [15:0] wb_index;

  int n_checks = 0, n_fail = 0;
  bit done_run = 0;

  dirty_tracker #(.NUM_BLOCKS(NB)) uut (
    .clk(clk), .rst(rst), .blk_exp(blk_exp), .win_blocks(win_blocks),
    .req_valid(req_valid), .req_kind(req_kind), .req_start(req_start),
    .req_len(req_len), .req_err(req_err), .wipe(wipe),
    .flush_start(flush_start), .flush_busy(flush_busy),
    .flush_done(flush_done), .wb_valid(wb_valid), .wb_index(wb_index),
    .wb_ready(wb_ready)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  bit m_dirty[NB];
  bit m_valid, m_busy, m_done, m_err;
  int m_idx;

  always @(posedge clk) begin
    longint cnt, lim, e;
    int low;
    bit any, ok;
    if (rst) begin
      foreach (m_dirty[i]) m_dirty[i] = 0;
      m_valid = 0; m_busy = 0; m_done = 0; m_err = 0; m_idx = 0;
    end else begin
      cnt = req_kind ? longint'(req_len)
                     : (longint'(req_len) + (64'd1 << blk_exp) - 1) >> blk_exp;
      e   = longint'(req_start) + cnt;
      lim = (win_blocks > NB) ? NB : win_blocks;
      ok  = req_valid && (e <= lim);
      m_err = req_valid && !ok;
      any = 0; low = 0;
      for (int i = NB - 1; i >= 0; i--) if (m_dirty[i]) begin any = 1; low = i; end
      if (wipe) begin
        foreach (m_dirty[i]) m_dirty[i] = 0;
        m_valid = 0; m_busy = 0; m_done = 0; m_idx = 0;
      end else begin
        m_done = 0;
        if (m_busy) begin
          if (m_valid) begin
            if (wb_ready) begin m_dirty[m_idx] = 0; m_valid = 0; end
          end else if (any) begin m_valid = 1; m_idx = low; end
          else begin m_busy = 0; m_done = 1; end
        end else if (flush_start) m_busy = 1;
        if (ok) for (longint b = req_start; b < e; b++) m_dirty[b] = 1;
      end
    end
  end

  always @(negedge clk) if (!rst && !done_run) begin
    n_checks++;
    if (wb_valid !== m_valid || (m_valid && wb_index !== 16'(m_idx))) begin
      n_fail++;
      $display("FAIL R6/R11 model: wb_valid=%0b idx=%0d expected %0b idx=%0d",
               wb_valid, wb_index, m_valid, m_idx);
    end
    if (flush_done !== m_done || flush_busy !== m_busy) begin
      n_fail++;
      $display("FAIL R8 model: done=%0b busy=%0b expected %0b %0b",
               flush_done, flush_busy, m_done, m_busy);
    end
    if (req_err !== m_err) begin
      n_fail++;
      $display("FAIL R5 model: req_err=%0b expected %0b", req_err, m_err);
    end
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int last_err;
  task automatic send(bit kind, int start, int len);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_start = 16'(start); req_len = 32'(len);
    @(negedge clk);
    req_valid = 0;
    last_err = req_err;
  endtask

  int got[$];
  task automatic do_flush(bit stall);
    got.delete();
    @(negedge clk);
    flush_start = 1;
    @(negedge clk);
    flush_start = 0;
    while (!flush_done) begin
      wb_ready = stall ? 1'($urandom_range(0, 1)) : 1'b1;
      if (wb_valid && wb_ready) got.push_back(int'(wb_index));
      @(negedge clk);
    end
    wb_ready = 1;
  endtask

  task automatic chk_list(string req, int exp[$]);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %p expected %p", req, got, exp);
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 busy", flush_busy, 0);
    chk("R1 done", flush_done, 0);
    chk("R1 err", req_err, 0);

    // R10: empty flush, done two edges after start
    @(negedge clk); flush_start = 1;
    @(negedge clk); flush_start = 0; chk("R10 busy", flush_busy, 1);
    @(negedge clk); chk("R10 done", flush_done, 1);
    @(negedge clk); chk("R8 done one cycle", flush_done, 0);

    // R2: rounding (exp 4, 16-byte blocks)
    send(0, 3, 17);  chk("R2 err", last_err, 0);
    send(0, 10, 16);
    do_flush(0);     chk_list("R2 R6 mark span", '{3, 4, 10});

    // R3: zero length
    send(0, 5, 0);   chk("R3 err", last_err, 0);
    do_flush(0);     chk_list("R3 zero marks nothing", '{});

    // R4 / R5
    send(1, 20, 3);
    send(0, 38, 48); chk("R5 err mark past window", last_err, 1);
    @(negedge clk);  chk("R5 err single cycle", req_err, 0);
    send(1, 39, 2);  chk("R5 err erase past window", last_err, 1);
    do_flush(0);     chk_list("R4 R5 erase only", '{20, 21, 22});
    send(1, 37, 3);  chk("R5 exact limit accepted", last_err, 0);
    do_flush(1);     chk_list("R5 R6 limit blocks stalled", '{37, 38, 39});

    // R7: repeated marks emitted once
    send(0, 7, 1); send(0, 7, 5); send(1, 6, 2);
    do_flush(1);     chk_list("R7 once per flush", '{6, 7});
    do_flush(0);     chk_list("R7 cleared after accept", '{});

    // R2 with exp 0
    blk_exp = 5'd0;
    send(0, 30, 3);
    do_flush(0);     chk_list("R2 exp0", '{30, 31, 32});
    blk_exp = 5'd4;

    // R11: mark during flush
    send(1, 2, 1);
    @(negedge clk); flush_start = 1; wb_ready = 0;
    @(negedge clk); flush_start = 0;
    req_valid = 1; req_kind = 1; req_start = 16'd9; req_len = 32'd1;
    @(negedge clk); req_valid = 0;
    got.delete();
    wb_ready = 1;
    while (!flush_done) begin
      if (wb_valid && wb_ready) got.push_back(int'(wb_index));
      @(negedge clk);
    end
    chk_list("R11 late mark flushed", '{2, 9});

    // R9: wipe mid flush
    send(1, 0, 5);
    @(negedge clk); flush_start = 1; wb_ready = 0;
    @(negedge clk); flush_start = 0;
    @(negedge clk); chk("R9 offering before wipe", wb_valid, 1);
    wipe = 1;
    @(negedge clk); wipe = 0;
    chk("R9 valid low", wb_valid, 0);
    chk("R9 busy low", flush_busy, 0);
    wb_ready = 1;
    do_flush(0);     chk_list("R9 all discarded", '{});

    // random phase, model compared every cycle
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      req_valid   = ($urandom_range(0, 3) == 0);
      req_kind    = 1'($urandom_range(0, 1));
      req_start   = 16'($urandom_range(0, 45));
      req_len     = req_kind ? 32'($urandom_range(0, 6)) : 32'($urandom_range(0, 90));
      blk_exp     = 5'($urandom_range(3, 5));
      flush_start = ($urandom_range(0, 15) == 0);
      wipe        = ($urandom_range(0, 199) == 0);
      wb_ready    = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    req_valid = 0; flush_start = 0; wipe = 0; wb_ready = 1;
    cyc = 0;
    repeat (200) @(negedge clk);
    done_run = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule